// File: doc/BRIEF.md
# Scatter-Gather Descriptor Dispatcher

This block is the software-facing front end of a scatter-gather DMA engine. Software builds each eight-word descriptor in staging registers through a descriptor write port. The descriptor enters an internal FIFO as one indivisible entry only when software writes the last word, the control word, with its commit bit set. A downstream mover takes descriptors through a valid/ready command interface and reports each finished descriptor, in order, through a one-cycle completion strobe that carries an error code and an early-termination flag.

A control/status port gives software control over the dispatcher. Software can halt descriptor issue, arm automatic halting on errors or early terminations, and enable the interrupt line. It can also start a timed internal flush. While the flush runs, a visible resetting flag is set and every write is ignored. Sticky status flags record why the dispatcher stopped and whether an interrupt is pending. Software clears each of them by writing a 1 to its bit.

Top module: `dma_dispatch_csr`

## Requirements
- R1: Descriptor word k (desc_addr = k, 0..7) is only staged; nothing enters the FIFO unless word 7 is written with bit 31 set. That write enqueues one entry with word k at cmd_desc[32k+31:32k], and word 7 is the written value.
- R2: cmd_valid is high whenever the FIFO is non-empty and issue is not halted. A descriptor is removed when cmd_valid and cmd_ready are both high, and descriptors leave in commit order.
- R3: The FIFO holds DEPTH entries. A commit write while it is full is ignored. Status bit 2 reports full and bit 1 reports empty.
- R4: Status (csr_addr 0) reports busy in bit 0, meaning entries are queued or in flight. It also carries the bits named in R3, R5, R8, R9, R10, R11 and R7 (bit 9). Writing 1 to bits 7, 8 or 9 clears them.
- R5: csr_addr 2 returns the queued count in both 16-bit halves. csr_addr 3 returns the in-flight count. Status bit 3 means none are in flight and bit 4 means RDEPTH are in flight. At that limit, cmd_valid stays low.
- R6: csr_addr 4 returns bits 15:0 of word 3 of the last issued descriptor in both halves.
- R7: A completion sets interrupt pending (status bit 9) when its descriptor's control bit 14 is set, when rsp_err ANDed with control bits 23:16 is nonzero, or when rsp_early is high and control bit 15 is set. irq equals pending AND control-register bit 4.
- R8: With control-register bit 2 set, a completion with nonzero rsp_err sets status bit 7 and halts issue until bit 7 is cleared.
- R9: With control-register bit 3 set, a completion with rsp_early sets status bit 8 and halts issue until bit 8 is cleared.
- R10: Control-register bit 0 (stop) or bit 5 (stop issue) halts issue. Status bit 5 is the OR of bits 0, 5 and the two sticky stop flags.
- R11: Writing control-register bit 1 empties the FIFO and the in-flight tracker and clears bits 7–9 and the sequence value. Resetting (status bit 6, and control-register bit 1 on read) then holds for RST_CYCLES cycles, during which all writes and completions are ignored.
- R12: A completion strobe with nothing in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr | input | 1 | Descriptor word write strobe |
| desc_addr | input | 3 | Descriptor word index |
| desc_wdata | input | 32 | Descriptor word data |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word index (byte offset / 4) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from csr_addr |
| cmd_valid | output | 1 | Descriptor available to the mover |
| cmd_ready | input | 1 | Mover accepts the descriptor |
| cmd_desc | output | 256 | Head descriptor, word k at bits 32k+31:32k |
| rsp_valid | input | 1 | Completion strobe for the oldest in-flight descriptor |
| rsp_err | input | 8 | Completion error code |
| rsp_early | input | 1 | Completion ended early |
| irq | output | 1 | Interrupt request |

## Verification
Every write, commit, issue and completion shows up in the registers and in irq one clock edge after the edge that samples it. cmd_valid and cmd_desc follow the current state with no added delay, and csr_rdata follows csr_addr within the same cycle. The bench drives inputs just after a rising edge, advances its queue model on that same edge, and compares every output on the following falling edge. A halt or stop that is caused by a completion therefore first blocks issue one cycle after that completion. The resetting flag is checked both inside and after its RST_CYCLES window.

// File: rtl/dma_dispatch_csr.sv
module dma_dispatch_csr #(
  parameter int DEPTH      = 4,
  parameter int RDEPTH     = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         desc_wr,
  input  logic [2:0]   desc_addr,
  input  logic [31:0]  desc_wdata,
  input  logic         csr_wr,
  input  logic [2:0]   csr_addr,
  input  logic [31:0]  csr_wdata,
  output logic [31:0]  csr_rdata,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic [255:0] cmd_desc,
  input  logic         rsp_valid,
  input  logic [7:0]   rsp_err,
  input  logic         rsp_early,
  output logic         irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int RAW = $clog2(RDEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int RCW = $clog2(RDEPTH + 1);
  localparam int RSW = $clog2(RST_CYCLES + 1);

  logic [31:0]    stage [7];
  logic [255:0]   mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic [9:0]     tags [RDEPTH];
  logic [RAW-1:0] twp, trp;
  logic [RCW-1:0] infl;
  logic [5:0]     ctl;
  logic           stop_err, stop_early, irq_pend;
  logic [RSW-1:0] rcnt;
  logic [15:0]    last_seq;

  logic resetting, full, empty, rfull, stopped, push, pop, rsp_ok, irq_set;
  logic ctl_wr, sts_wr;
  logic [9:0]   head_tag;
  logic [9:0]   status;
  logic [255:0] new_desc;
  logic         unused_bits;

  assign resetting = rcnt != '0;
  assign full      = cnt == CW'(DEPTH);
  assign empty     = cnt == '0;
  assign rfull     = infl == RCW'(RDEPTH);
  assign stopped   = ctl[0] | ctl[5] | stop_err | stop_early;
  assign cmd_valid = !empty && !stopped && !resetting && !rfull;
  assign cmd_desc  = mem[rp];
  assign pop       = cmd_valid && cmd_ready;
  assign push      = desc_wr && desc_addr == 3'd7 && desc_wdata[31] && !full && !resetting;
  assign rsp_ok    = rsp_valid && infl != '0 && !resetting;
  assign ctl_wr    = csr_wr && csr_addr == 3'd1 && !resetting;
  assign sts_wr    = csr_wr && csr_addr == 3'd0 && !resetting;
  assign head_tag  = tags[trp];
  assign irq_set   = rsp_ok && (head_tag[0] || (|(rsp_err & head_tag[9:2])) || (rsp_early && head_tag[1]));
  assign new_desc  = {desc_wdata, stage[6], stage[5], stage[4], stage[3], stage[2], stage[1], stage[0]};
  assign status    = {irq_pend, stop_early, stop_err, resetting, stopped, rfull, infl == '0, full, empty,
                      !empty || infl != '0};
  assign irq       = irq_pend & ctl[4];
  assign unused_bits = ^{csr_wdata[31:10], csr_wdata[6]};

  always_comb begin
    case (csr_addr)
      3'd0:    csr_rdata = {22'd0, status};
      3'd1:    csr_rdata = {26'd0, ctl[5:2], resetting, ctl[0]};
      3'd2:    csr_rdata = {16'(cnt), 16'(cnt)};
      3'd3:    csr_rdata = 32'(infl);
      3'd4:    csr_rdata = {last_seq, last_seq};
      default: csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) stage[i] <= '0;
    end else if (desc_wr && !resetting && desc_addr != 3'd7) begin
      stage[desc_addr] <= desc_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      twp <= '0; trp <= '0; infl <= '0;
      ctl <= '0; stop_err <= 1'b0; stop_early <= 1'b0; irq_pend <= 1'b0;
      rcnt <= '0; last_seq <= '0;
    end else if (ctl_wr && csr_wdata[1]) begin
      wp <= '0; rp <= '0; cnt <= '0;
      twp <= '0; trp <= '0; infl <= '0;
      stop_err <= 1'b0; stop_early <= 1'b0; irq_pend <= 1'b0;
      last_seq <= '0;
      rcnt <= RSW'(RST_CYCLES);
      ctl <= {csr_wdata[5:2], 1'b0, csr_wdata[0]};
    end else begin
      if (resetting) rcnt <= rcnt - 1'b1;
      if (ctl_wr) ctl <= {csr_wdata[5:2], 1'b0, csr_wdata[0]};
      if (push) begin
        mem[wp] <= new_desc;
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) begin
        tags[twp] <= {mem[rp][247:240], mem[rp][239], mem[rp][238]};
        twp <= (twp == RAW'(RDEPTH - 1)) ? '0 : twp + 1'b1;
        rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        last_seq <= mem[rp][111:96];
      end
      if (rsp_ok) trp <= (trp == RAW'(RDEPTH - 1)) ? '0 : trp + 1'b1;
      cnt  <= cnt + CW'(push) - CW'(pop);
      infl <= infl + RCW'(pop) - RCW'(rsp_ok);
      if (sts_wr && csr_wdata[7]) stop_err   <= 1'b0;
      if (sts_wr && csr_wdata[8]) stop_early <= 1'b0;
      if (sts_wr && csr_wdata[9]) irq_pend   <= 1'b0;
      if (rsp_ok && ctl[2] && rsp_err != '0) stop_err <= 1'b1;
      if (rsp_ok && ctl[3] && rsp_early) stop_early <= 1'b1;
      if (irq_set) irq_pend <= 1'b1;
    end
  end
endmodule

module dma_dispatch_csr_chk #(
  parameter int DEPTH  = 4,
  parameter int RDEPTH = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [$clog2(DEPTH+1)-1:0]    cnt,
  input logic [$clog2(RDEPTH+1)-1:0]   infl,
  input logic [5:0]                    ctl,
  input logic                          stop_err,
  input logic                          stop_early,
  input logic                          resetting,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic                          irq,
  input logic                          go_write,
  input logic                          rst_write,
  input logic                          rsp_valid,
  input logic [7:0]                    rsp_err
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH+1))'(DEPTH));

  p_full_go_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == ($clog2(DEPTH+1))'(DEPTH) && go_write && !(cmd_valid && cmd_ready) && !rst_write)
      |=> cnt == ($clog2(DEPTH+1))'(DEPTH));

  p_halt_blocks_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] || ctl[5] || stop_err || stop_early || resetting) |-> !cmd_valid);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[4] |-> !irq);

  p_stop_on_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && infl != '0 && !resetting && rsp_err != '0 && ctl[2] && !rst_write) |=> stop_err);

  p_reset_flushes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetting) |-> (cnt == '0 && infl == '0 && !stop_err && !stop_early));
endmodule

bind dma_dispatch_csr dma_dispatch_csr_chk #(.DEPTH(DEPTH), .RDEPTH(RDEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .infl(infl), .ctl(ctl),
  .stop_err(stop_err), .stop_early(stop_early), .resetting(resetting),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .irq(irq),
  .go_write(desc_wr && desc_addr == 3'd7 && desc_wdata[31]),
  .rst_write(csr_wr && csr_addr == 3'd1 && csr_wdata[1]),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/dma_dispatch_csr_tb.sv
module dma_dispatch_csr_tb_top;
  localparam int DEPTH = 4, RDEPTH = 4, RST_CYCLES = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_wr = 0, csr_wr = 0, cmd_ready = 0, rsp_valid = 0, rsp_early = 0;
  logic [2:0] desc_addr = 0, csr_addr = 0;
  logic [31:0] desc_wdata = 0, csr_wdata = 0, csr_rdata;
  logic [7:0] rsp_err = 0;
  logic cmd_valid, irq;
  logic [255:0] cmd_desc;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_dispatch_csr #(.DEPTH(DEPTH), .RDEPTH(RDEPTH), .RST_CYCLES(RST_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .desc_wr(desc_wr), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
    .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_desc(cmd_desc),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_early(rsp_early), .irq(irq));

  // reference model
  logic [255:0] mq[$];
  logic [31:0]  tq[$];
  logic [31:0]  sw [7];
  logic [5:0]   mctl;
  bit m_se, m_sel, m_ip;
  int m_rc;
  logic [15:0] m_seq;

  function automatic bit m_valid();
    return mq.size() > 0 && !(mctl[0] || mctl[5] || m_se || m_sel || m_rc > 0) && tq.size() < RDEPTH;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    logic stp;
    stp = mctl[0] | mctl[5] | m_se | m_sel;
    case (a)
      3'd0: return {22'd0, m_ip, m_sel, m_se, m_rc > 0, stp, tq.size() == RDEPTH, tq.size() == 0,
                    mq.size() == DEPTH, mq.size() == 0, mq.size() > 0 || tq.size() > 0};
      3'd1: return {26'd0, mctl[5:2], m_rc > 0, mctl[0]};
      3'd2: return {16'(mq.size()), 16'(mq.size())};
      3'd3: return 32'(tq.size());
      3'd4: return {m_seq, m_seq};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); tq.delete(); mctl = '0; m_se = 0; m_sel = 0; m_ip = 0; m_rc = 0; m_seq = '0;
      for (int i = 0; i < 7; i++) sw[i] = '0;
    end else begin
      bit res, pop, rok, go, flush;
      logic [31:0] t;
      logic [255:0] d, h;
      res   = m_rc > 0;
      pop   = m_valid() && cmd_ready;
      rok   = rsp_valid && tq.size() > 0 && !res;
      go    = desc_wr && desc_addr == 3'd7 && desc_wdata[31] && mq.size() < DEPTH && !res;
      flush = csr_wr && csr_addr == 3'd1 && csr_wdata[1] && !res;
      d = {desc_wdata, sw[6], sw[5], sw[4], sw[3], sw[2], sw[1], sw[0]};
      if (csr_wr && csr_addr == 3'd0 && !res) begin
        if (csr_wdata[7]) m_se = 0;
        if (csr_wdata[8]) m_sel = 0;
        if (csr_wdata[9]) m_ip = 0;
      end
      if (rok) begin
        t = tq.pop_front();
        if (t[14] || (|(t[23:16] & rsp_err)) || (rsp_early && t[15])) m_ip = 1;
        if (mctl[2] && rsp_err != 0) m_se = 1;
        if (mctl[3] && rsp_early) m_sel = 1;
      end
      if (pop) begin
        h = mq.pop_front();
        tq.push_back(h[255:224]);
        m_seq = h[111:96];
      end
      if (go) mq.push_back(d);
      if (desc_wr && !res && desc_addr != 3'd7) sw[desc_addr] = desc_wdata;
      if (csr_wr && csr_addr == 3'd1 && !res) mctl = {csr_wdata[5:2], 1'b0, csr_wdata[0]};
      if (m_rc > 0) m_rc--;
      if (flush) begin
        mq.delete(); tq.delete(); m_se = 0; m_sel = 0; m_ip = 0; m_seq = '0; m_rc = RST_CYCLES;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "cmd_valid", 32'(cmd_valid), 32'(m_valid()));
      if (m_valid())
        for (int k = 0; k < 8; k++) chk("R1", "cmd_desc word", cmd_desc[32*k +: 32], mq[0][32*k +: 32]);
      chk("R7", "irq", 32'(irq), 32'(m_ip & mctl[4]));
      case (csr_addr)
        3'd0:    chk("R4", "status", csr_rdata, m_read(csr_addr));
        3'd1:    chk("R11", "control", csr_rdata, m_read(csr_addr));
        3'd4:    chk("R6", "sequence", csr_rdata, m_read(csr_addr));
        default: chk("R5", "levels", csr_rdata, m_read(csr_addr));
      endcase
    end
  end

  task automatic dwr(input logic [2:0] a, input logic [31:0] v);
    desc_wr = 1; desc_addr = a; desc_wdata = v;
    @(posedge clk); #1; desc_wr = 0;
  endtask

  task automatic cwr(input logic [2:0] a, input logic [31:0] v);
    csr_wr = 1; csr_addr = a; csr_wdata = v;
    @(posedge clk); #1; csr_wr = 0; csr_addr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    csr_addr = a;
    @(negedge clk); v = csr_rdata;
  endtask

  task automatic rsp(input logic [7:0] e, input logic early);
    rsp_valid = 1; rsp_err = e; rsp_early = early;
    @(posedge clk); #1; rsp_valid = 0; rsp_err = 0; rsp_early = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] cw);
    for (int w = 0; w < 7; w++) dwr(3'(w), base + 32'(w));
    dwr(3'd7, cw);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    rd(0, v); chk("R4", "reset status", v, 32'h00A);
    chk("R2", "reset cmd_valid", 32'(cmd_valid), 0);
    chk("R7", "reset irq", 32'(irq), 0);
    cwr(1, 32'h1C);
    rd(1, v); chk("R10", "control readback", v, 32'h1C);
    put_desc(32'h100, 32'h0000_4000);
    rd(2, v); chk("R1", "no commit without go", v, 0);
    dwr(7, 32'h8000_4000);
    rd(2, v); chk("R5", "one queued", v, 32'h0001_0001);
    put_desc(32'h200, 32'h80FF_4000);
    put_desc(32'h300, 32'h8000_4000);
    put_desc(32'h400, 32'h8000_0000);
    rd(0, v); chk("R3", "full status", v, 32'h00D);
    dwr(7, 32'h8000_0000);
    rd(2, v); chk("R3", "go while full ignored", v, 32'h0004_0004);
    chk("R1", "head word0", cmd_desc[31:0], 32'h100);
    chk("R1", "head word7", cmd_desc[255:224], 32'h8000_4000);
    @(posedge clk); #1; cmd_ready = 1;
    repeat (4) @(posedge clk); #1; cmd_ready = 0;
    rd(3, v); chk("R5", "in flight", v, 4);
    rd(0, v); chk("R5", "tracker full status", v, 32'h013);
    rd(4, v); chk("R6", "last sequence", v, 32'h0403_0403);
    rsp(0, 0);
    rd(0, v); chk("R7", "pending after completion", v & 32'h200, 32'h200);
    chk("R7", "irq line", 32'(irq), 1);
    cwr(0, 32'h200);
    chk("R7", "irq cleared", 32'(irq), 0);
    rsp(8'h01, 0);
    rd(0, v); chk("R8", "stopped on error", v, 32'h2A3);
    put_desc(32'h500, 32'h8000_4000);
    cmd_ready = 1;
    rd(2, v); chk("R8", "no issue while stopped", v, 32'h0001_0001);
    chk("R8", "cmd_valid low", 32'(cmd_valid), 0);
    cwr(0, 32'h280);
    @(posedge clk); #1; cmd_ready = 0;
    rd(2, v); chk("R8", "issue resumes", v, 0);
    rsp(0, 1);
    rd(0, v); chk("R9", "stopped on early", v, 32'h323);
    cwr(0, 32'h300);
    cwr(1, 32'h1D);
    put_desc(32'h600, 32'h8000_4000);
    cmd_ready = 1;
    rd(0, v); chk("R10", "stop bit halts", v & 32'h21, 32'h21);
    cwr(1, 32'h3C);
    rd(2, v); chk("R10", "stop issue halts", v, 32'h0001_0001);
    cwr(1, 32'h1C);
    @(posedge clk); #1; cmd_ready = 0;
    rd(3, v); chk("R10", "issued after release", v, 3);
    repeat (3) rsp(0, 0);
    rsp(8'h0F, 1);
    rd(3, v); chk("R12", "stray completion ignored", v, 0);
    rd(0, v); chk("R12", "no stop from stray", v & 32'h180, 0);
    cwr(0, 32'h380);
    put_desc(32'h700, 32'h8000_4000);
    cwr(1, 32'h12);
    rd(0, v); chk("R11", "resetting status", v, 32'h04A);
    rd(1, v); chk("R11", "reset bit reads set", v, 32'h12);
    dwr(7, 32'h8000_0000);
    rd(2, v); chk("R11", "go ignored in reset", v, 0);
    repeat (4) @(posedge clk);
    rd(1, v); chk("R11", "reset self-clears", v, 32'h10);
    rd(4, v); chk("R11", "sequence cleared", v, 0);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule